// File: doc/BRIEF.md
# Dual-Section Phase-Frequency Detector with Lock Detection

This block serves two frequency-synthesizer sections, a low band (section 0) and a high band (section 1). Each section receives a reference strobe and a divided-VCO strobe. Both are one-cycle pulses synchronous to the oscillator clock. For each section the block produces a three-state charge-pump drive: pull high, pull low, or released (high impedance). A per-section bit sets the polarity of that drive.

The block times the gap between the two strobes of each comparison in oscillator cycles, using a saturating counter. From that measure it keeps a lock flag per section with hysteresis. A section can be parked in power save. In power save its pump is released at once and the section counts as locked in the combined lock output. After reset, and after a section leaves power save, its first comparison is suppressed. A monitor pin shows either the combined lock or one of the four raw strobes.

Top module: `pfd_dual_lock`

## Requirements
- R1: With `pol_pos[i]`=1, a reference strobe arriving before the divided strobe raises `pump_hi[i]` from the cycle after the reference strobe. A divided strobe arriving first raises `pump_lo[i]` in the same way. The leading pin stays high until the cycle after the trailing strobe. When neither is pending, both pins are 0 (high impedance).
- R2: With `pol_pos[i]`=0, the roles of `pump_hi[i]` and `pump_lo[i]` in R1 are swapped.
- R3: When both strobes of a section arrive in the same cycle, `pump_hi[i]` and `pump_lo[i]` are both 1 for exactly one cycle and then both 0. A non-zero error likewise ends with one cycle in which both pins are 1.
- R4: The phase error of a comparison is the number of cycles between its two strobes. It saturates at 2^ERR_W-1 (15 by default) and never wraps, so a gap of 16 cycles still counts as a large error.
- R5: A completed comparison whose error is at least UNLOCK_WIN (3) clears `sec_locked[i]`, visible two cycles after the trailing strobe.
- R6: `sec_locked[i]` rises after LOCK_RUN (3) consecutive comparisons with error below LOCK_WIN (2). An error between the two windows leaves the flag unchanged and restarts the run.
- R7: While `pwr_save[i]`=1, both pump pins of the section are 0 in the same cycle. From the next cycle `sec_locked[i]` is 0 and the lock run is cleared.
- R8: The first comparison after reset, or after `pwr_save[i]` falls, drives neither pump pin and does not count toward or against lock.
- R9: `lock_all` is 1 exactly when every section is either locked or in power save.
- R10: `mon_out` is combinational. With `tap_en`=0 it equals `lock_all`. With `tap_en`=1, the code {`tap_div`,`tap_sec`} picks the strobe shown: 00 = low-band reference, 01 = high-band reference, 10 = low-band divided, 11 = high-band divided.
- R11: After reset, all pump pins and `sec_locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 2 | Reference strobe per section |
| div_stb | input | 2 | Divided-VCO strobe per section |
| pwr_save | input | 2 | Power save per section, active high |
| pol_pos | input | 2 | Pump polarity per section |
| tap_en | input | 1 | Monitor shows a strobe instead of lock |
| tap_sec | input | 1 | Monitor section select |
| tap_div | input | 1 | Monitor picks divided rather than reference strobe |
| pump_hi | output | 2 | Pump drives high |
| pump_lo | output | 2 | Pump drives low |
| sec_locked | output | 2 | Lock flag per section |
| lock_all | output | 1 | Combined lock |
| mon_out | output | 1 | Monitor output |

## Verification
A strobe driven before clock edge k appears on the pump pins right after edge k. The pins release, and the lock flag updates, after the edge that follows the trailing strobe's capture edge. A comparison with gap g therefore settles g+2 edges after its first strobe. Each scenario task drives at the falling edge and, at each falling edge, compares the pins against the value predicted for that exact edge count. Power-save gating of the pump and the monitor multiplexer are combinational, so those checks sample shortly after the input changes, within the same cycle.

// File: rtl/pfd_pkg.sv
// Shared definitions for the dual-section phase detector.
package pfd_pkg;
    localparam int unsigned SECTIONS = 2;

    // Monitor tap code {divided, section}; the encoding is decoded by the tap mux.
    typedef enum logic [1:0] {
        TAP_REF_LO = 2'b00,
        TAP_REF_HI = 2'b01,
        TAP_DIV_LO = 2'b10,
        TAP_DIV_HI = 2'b11
    } tap_e;
endpackage

// File: rtl/pfd_core.sv
// Three-state phase-frequency detector for one section.
// Assumes ref_stb and div_stb are one-cycle strobes on clk.
// Pump pins are gated off during power save and during the first
// (suppressed) comparison after reset or power-save release.
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic div_stb,
    input  logic pwr_save,
    input  logic pol_pos,
    output logic lead_ref,
    output logic lead_div,
    output logic blank,
    output logic pump_hi,
    output logic pump_lo
);
    logic quiet;

    // Pending-edge flags; cleared one cycle after both are set.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_save) begin
            lead_ref <= 1'b0;
            lead_div <= 1'b0;
        end else if (lead_ref && lead_div) begin
            lead_ref <= ref_stb;
            lead_div <= div_stb;
        end else begin
            lead_ref <= lead_ref | ref_stb;
            lead_div <= lead_div | div_stb;
        end
    end

    // Suppression flag: set by reset or power save, cleared by the first completed comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_save) blank <= 1'b1;
        else if (lead_ref && lead_div) blank <= 1'b0;
    end

    // Polarity steering and output gating.
    always_comb begin
        quiet   = pwr_save | blank;
        pump_hi = !quiet && (pol_pos ? lead_ref : lead_div);
        pump_lo = !quiet && (pol_pos ? lead_div : lead_ref);
    end

    AST_HOLD_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_ref && !lead_div && !pwr_save) |=> lead_ref); // R1
    AST_HOLD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_div && !lead_ref && !pwr_save) |=> lead_div); // R1
endmodule

// File: rtl/pfd_lock.sv
// Lock detector for one section. Counts cycles while exactly one edge
// is pending (saturating), then judges each completed comparison
// against the lock and unlock windows.
// Assumes LOCK_WIN <= UNLOCK_WIN <= 2**ERR_W-1.
module pfd_lock #(
    parameter int unsigned ERR_W      = 4,
    parameter int unsigned LOCK_WIN   = 2,
    parameter int unsigned UNLOCK_WIN = 3,
    parameter int unsigned LOCK_RUN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_ref,
    input  logic lead_div,
    input  logic blank,
    input  logic pwr_save,
    output logic locked
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
    localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);

    logic [ERR_W-1:0] err_q;
    logic [RUN_W-1:0] run_q;
    logic done, upd;

    always_comb begin
        done = lead_ref & lead_div;
        upd  = done & ~blank & ~pwr_save;
    end

    // Saturating phase-error counter.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_save || done) err_q <= '0;
        else if ((lead_ref ^ lead_div) && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end

    // Lock flag with hysteresis and consecutive-run qualification.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_save) begin
            locked <= 1'b0;
            run_q  <= '0;
        end else if (upd) begin
            if (int'(err_q) >= UNLOCK_WIN) begin
                locked <= 1'b0;
                run_q  <= '0;
            end else if (int'(err_q) < LOCK_WIN) begin
                if (run_q + 1'b1 >= RUN_TOP) locked <= 1'b1;
                if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q == ERR_MAX && !done && !pwr_save) |=> err_q == ERR_MAX); // R4
    AST_WIDE_ERR_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && int'(err_q) >= UNLOCK_WIN) |=> !locked); // R5
    AST_LOCK_AFTER_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(upd)); // R6
    AST_SAVE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |=> !locked); // R7
endmodule

// File: rtl/pfd_tap_mux.sv
// Monitor output selector: combined lock, or one raw strobe picked by a tap code.
module pfd_tap_mux
    import pfd_pkg::*;
(
    input  logic       lock_all,
    input  logic       tap_en,
    input  logic       tap_sec,
    input  logic       tap_div,
    input  logic [1:0] ref_stb,
    input  logic [1:0] div_stb,
    output logic       mon_out
);
    // Source selection.
    always_comb begin
        if (!tap_en) begin
            mon_out = lock_all;
        end else begin
            case (tap_e'({tap_div, tap_sec}))
                TAP_REF_LO: mon_out = ref_stb[0];
                TAP_REF_HI: mon_out = ref_stb[1];
                TAP_DIV_LO: mon_out = div_stb[0];
                default:    mon_out = div_stb[1];
            endcase
        end
    end
endmodule

// File: rtl/pfd_dual_lock.sv
// Two-section phase detector top: one detector and one lock judge per
// section, combined lock, and monitor tap. Assumes all strobes are
// synchronous one-cycle pulses on clk.
module pfd_dual_lock
    import pfd_pkg::*;
#(
    parameter int unsigned ERR_W      = 4,
    parameter int unsigned LOCK_WIN   = 2,
    parameter int unsigned UNLOCK_WIN = 3,
    parameter int unsigned LOCK_RUN   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_stb,
    input  logic [1:0] div_stb,
    input  logic [1:0] pwr_save,
    input  logic [1:0] pol_pos,
    input  logic       tap_en,
    input  logic       tap_sec,
    input  logic       tap_div,
    output logic [1:0] pump_hi,
    output logic [1:0] pump_lo,
    output logic [1:0] sec_locked,
    output logic       lock_all,
    output logic       mon_out
);
    logic [SECTIONS-1:0] lead_ref, lead_div, blank;

    for (genvar i = 0; i < SECTIONS; i++) begin : g_sec
        pfd_core u_core (
            .clk(clk), .rst_n(rst_n),
            .ref_stb(ref_stb[i]), .div_stb(div_stb[i]),
            .pwr_save(pwr_save[i]), .pol_pos(pol_pos[i]),
            .lead_ref(lead_ref[i]), .lead_div(lead_div[i]), .blank(blank[i]),
            .pump_hi(pump_hi[i]), .pump_lo(pump_lo[i])
        );
        pfd_lock #(
            .ERR_W(ERR_W), .LOCK_WIN(LOCK_WIN),
            .UNLOCK_WIN(UNLOCK_WIN), .LOCK_RUN(LOCK_RUN)
        ) u_lock (
            .clk(clk), .rst_n(rst_n),
            .lead_ref(lead_ref[i]), .lead_div(lead_div[i]),
            .blank(blank[i]), .pwr_save(pwr_save[i]),
            .locked(sec_locked[i])
        );
    end

    // Combined lock: every section locked or parked.
    always_comb lock_all = &(sec_locked | pwr_save);

    pfd_tap_mux u_tap (
        .lock_all(lock_all), .tap_en(tap_en), .tap_sec(tap_sec), .tap_div(tap_div),
        .ref_stb(ref_stb), .div_stb(div_stb), .mon_out(mon_out)
    );

    AST_PARKED_READS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&pwr_save) |-> lock_all); // R9
endmodule

// File: tb/pfd_dual_lock_tb.sv
`timescale 1ns/1ps
module pfd_dual_lock_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ref_stb = '0, div_stb = '0, pwr_save = 2'b10, pol_pos = 2'b11;
    logic tap_en = 1'b0, tap_sec = 1'b0, tap_div = 1'b0;
    logic [1:0] pump_hi, pump_lo, sec_locked;
    logic lock_all, mon_out;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pfd_dual_lock u_dut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .div_stb(div_stb),
        .pwr_save(pwr_save), .pol_pos(pol_pos), .tap_en(tap_en),
        .tap_sec(tap_sec), .tap_div(tap_div), .pump_hi(pump_hi),
        .pump_lo(pump_lo), .sec_locked(sec_locked), .lock_all(lock_all),
        .mon_out(mon_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected pump pins from pending edges, polarity and suppression.
    task automatic pump_chk(input int s, input bit up, input bit dn, input bit quiet, input string tag);
        chk(tag, pump_hi[s], quiet ? 0 : (pol_pos[s] ? up : dn));
        chk(tag, pump_lo[s], quiet ? 0 : (pol_pos[s] ? dn : up));
    endtask

    // One comparison with the given gap; returns at the cycle the lock update is visible.
    task automatic cmp(input int s, input int gap, input bit ref_first, input bit quiet, input string tag);
        @(negedge clk);
        if (gap == 0) begin ref_stb[s] = 1; div_stb[s] = 1; end
        else if (ref_first) ref_stb[s] = 1;
        else div_stb[s] = 1;
        for (int k = 1; k <= gap; k++) begin
            @(negedge clk);
            if (k == 1) pump_chk(s, ref_first, !ref_first, quiet, tag);
            ref_stb[s] = 0; div_stb[s] = 0;
            if (k == gap) begin
                if (ref_first) div_stb[s] = 1; else ref_stb[s] = 1;
            end
        end
        @(negedge clk);
        pump_chk(s, 1, 1, quiet, tag);
        ref_stb[s] = 0; div_stb[s] = 0;
        @(negedge clk);
        pump_chk(s, 0, 0, quiet, tag);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 pump_hi", pump_hi, 0);
        chk("R11 pump_lo", pump_lo, 0);
        chk("R11 sec_locked", sec_locked, 0);
        chk("R10 mon shows lock_all", mon_out, lock_all);
    endtask

    task automatic t_blank_first;
        cmp(0, 3, 1, 1, "R8 first comparison suppressed");
    endtask

    task automatic t_polarity;
        cmp(0, 3, 1, 0, "R1 ref leads pos");
        cmp(0, 2, 0, 0, "R1 div leads pos");
        pol_pos[0] = 0;
        cmp(0, 1, 1, 0, "R2 ref leads neg");
        pol_pos[0] = 1;
    endtask

    task automatic t_deadzone;
        cmp(0, 0, 1, 0, "R3 equal arrival");
        chk("R6 two good runs not yet locked", sec_locked[0], 0);
    endtask

    task automatic t_lock;
        cmp(0, 0, 1, 0, "R3 equal arrival");
        chk("R6 locked after third", sec_locked[0], 1);
        chk("R9 lock_all with other parked", lock_all, 1);
        cmp(0, 2, 1, 0, "R6 middle error");
        chk("R6 middle error holds lock", sec_locked[0], 1);
        cmp(0, 3, 0, 0, "R5 wide error");
        chk("R5 wide error unlocks", sec_locked[0], 0);
        chk("R9 lock_all follows", lock_all, 0);
        for (int n = 0; n < 3; n++) cmp(0, 1, 1, 0, "R6 relock");
        chk("R6 relocked", sec_locked[0], 1);
        cmp(0, 16, 1, 0, "R4 long gap");
        chk("R4 saturated error unlocks", sec_locked[0], 0);
        cmp(0, 2, 1, 0, "R6 middle error");
        cmp(0, 0, 1, 0, "R6 run restart");
        cmp(0, 0, 1, 0, "R6 run restart");
        chk("R6 middle error restarted run", sec_locked[0], 0);
        cmp(0, 0, 1, 0, "R6 run restart");
        chk("R6 locked after restarted run", sec_locked[0], 1);
    endtask

    task automatic t_second_section;
        @(negedge clk);
        pwr_save[1] = 0;
        @(negedge clk);
        chk("R9 unlocked active section", lock_all, 0);
        cmp(1, 0, 1, 1, "R8 release suppressed");
        cmp(1, 0, 1, 0, "R3 sec1");
        cmp(1, 0, 1, 0, "R3 sec1");
        chk("R8 suppressed comparison not counted", sec_locked[1], 0);
        cmp(1, 0, 1, 0, "R3 sec1");
        chk("R6 sec1 locked", sec_locked[1], 1);
        chk("R9 both locked", lock_all, 1);
    endtask

    task automatic t_power_save;
        @(negedge clk);
        ref_stb[0] = 1;
        @(negedge clk);
        pump_chk(0, 1, 0, 0, "R1 before save");
        ref_stb[0] = 0;
        pwr_save[0] = 1;
        #1;
        pump_chk(0, 0, 0, 1, "R7 save releases pump");
        @(negedge clk);
        chk("R7 save clears flag", sec_locked[0], 0);
        chk("R9 parked counts locked", lock_all, 1);
        pwr_save[0] = 0;
        cmp(0, 3, 1, 1, "R8 after release suppressed");
        chk("R8 no lock change", sec_locked[0], 0);
    endtask

    task automatic t_tap;
        pwr_save = 2'b11;
        tap_en = 1;
        for (int code = 0; code < 4; code++) begin
            for (int src = 0; src < 4; src++) begin
                @(negedge clk);
                {tap_div, tap_sec} = code[1:0];
                ref_stb = '0; div_stb = '0;
                if (src < 2) ref_stb[src] = 1; else div_stb[src-2] = 1;
                #1;
                chk("R10 tap select", mon_out, int'(src == code));
            end
        end
        @(negedge clk);
        ref_stb = '0; div_stb = '0; tap_en = 0;
        #1;
        chk("R10 lock on monitor", mon_out, 1);
    endtask

    initial begin
        t_reset();
        t_blank_first();
        t_polarity();
        t_deadzone();
        t_lock();
        t_second_section();
        t_power_save();
        t_tap();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule